// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave with Clock Enable Gating

This block is a two-wire serial slave that only accepts writes. A host addresses it with a start condition and the byte 0xD2. It then sends a command byte and a count byte, and after those a run of data bytes. The data bytes fill a bank of ten 8-bit configuration registers in order, always starting from register 0. Nothing can be read back, and there is no way to address an individual register. The command and count bytes are acknowledged but their contents are thrown away.

Register 2 drives a bank of eight clock gates. Each gate passes a free-running reference clock to its output or holds the output low. A new enable value is taken up only while that reference clock is low, so an output never produces a clipped pulse. A separate power-down input holds every gated output low but leaves the register contents alone. Only the power-on reset restores the defaults.

The serial lines are oversampled by the system clock `clk`. The data line is modelled as an input plus an open-drain pull-low enable.

Top module: `scs_slave`

## Requirements
- R1: A falling data line while the serial clock is high is a start condition. A rising data line while the serial clock is high is a stop condition. After a stop, no byte is acknowledged until the next start.
- R2: Bytes are received as 8 bits, most significant bit first, each bit sampled while the serial clock is high. An accepted byte is acknowledged by asserting `sda_pull` during the ninth clock. `sda_pull` changes only while the serial clock is low.
- R3: The first byte after a start is acknowledged only when it equals 0xD2 (7-bit address 0x69, write flag 0 in bit 0).
- R4: Any other first byte, including the read form 0xD3, is not acknowledged. No later byte of that transfer is acknowledged, and no register changes, until the next start.
- R5: The two bytes that follow an accepted address (command, then count) are acknowledged, and no register changes because of them.
- R6: Each later data byte is acknowledged and stored in the next register, beginning with register 0. Register k appears on `cfg_regs[8k+7:8k]`.
- R7: At most 10 data bytes are stored per transfer. The eleventh and every later data byte are neither acknowledged nor stored.
- R8: The register index returns to 0 at every start condition, including a repeated start with no stop before it.
- R9: Power-on reset loads register 2 with 0xFF and every other register with 0x00. Register contents otherwise change only through stored data bytes, and they survive the end of a transfer.
- R10: While `pwr_dn` is high, all gated clock outputs stay low and no register changes. When `pwr_dn` is released, the outputs resume as register 2 selects.
- R11: Bit i of register 2 controls `clk_out[i]`. A 1 passes `ref_clk[i]` and a 0 holds the output low.
- R12: An enable change takes effect only while the matching reference clock is low, so every output high pulse lasts a full reference high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| por | input | 1 | Power-on reset, synchronous, active high |
| pwr_dn | input | 1 | Power-down: forces gated outputs low, keeps registers |
| scl | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the wire |
| sda_pull | output | 1 | Open-drain pull-low enable for the data line (acknowledge) |
| ref_clk | input | 8 | Reference clocks to be gated |
| cfg_regs | output | 80 | Configuration registers, register k in bits 8k+7:8k |
| clk_out | output | 8 | Gated clock outputs |

## Verification
A wrong phase or bit count in the receive engine shows up at `sda_pull` within one byte time: the acknowledge appears in the wrong ninth-clock slot, or it is missing where it should be. A wrong register index shows up one system clock after the acknowledge begins, as the wrong slice of `cfg_regs` changing. The bench therefore compares every acknowledge slot against a queue of expected values and compares the whole register bank after each transfer. A bad enable path shows up within one reference period at `clk_out`: either as edges in the wrong outputs or as high pulses shorter than the reference high phase.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_CNT,
        ST_DATA,
        ST_SKIP
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic bit_val;
        logic scl_hi;
    } line_ev_t;

    function automatic phase_t next_phase(phase_t cur, logic acked);
        phase_t n;
        if (!acked) begin
            n = ST_SKIP;
        end else begin
            case (cur)
                ST_ADDR: n = ST_CMD;
                ST_CMD:  n = ST_CNT;
                ST_CNT:  n = ST_DATA;
                ST_DATA: n = ST_DATA;
                default: n = ST_SKIP;
            endcase
        end
        return n;
    endfunction

    function automatic logic [7:0] reg_default(int idx, int en_idx);
        return (idx == en_idx) ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/scs_line_sampler.sv
module scs_line_sampler
    import scs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output line_ev_t ev
);
    logic scl_q, sda_q, scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    always_comb begin
        ev.start   = scl_p & scl_q & sda_p & ~sda_q;
        ev.stop    = scl_p & scl_q & ~sda_p & sda_q;
        ev.rise    = scl_q & ~scl_p;
        ev.fall    = ~scl_q & scl_p;
        ev.bit_val = sda_q;
        ev.scl_hi  = scl_q;
    end
endmodule

// File: rtl/scs_byte_engine.sv
module scs_byte_engine
    import scs_pkg::*;
#(
    parameter int          NREG      = 10,
    parameter logic [7:0]  ADDR_BYTE = 8'hD2,
    localparam int         IDXW      = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  line_ev_t        ev,
    output logic            sda_pull,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output phase_t          phase,
    output logic [IDXW-1:0] idx
);
    localparam logic [IDXW-1:0] LIMIT = IDXW'(NREG);

    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       in_ack;
    logic       ack;
    logic       accept;

    always_comb begin
        case (phase)
            ST_ADDR: accept = (shreg == ADDR_BYTE);
            ST_CMD:  accept = 1'b1;
            ST_CNT:  accept = 1'b1;
            ST_DATA: accept = (idx < LIMIT);
            default: accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            phase   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            in_ack  <= 1'b0;
            ack     <= 1'b0;
            idx     <= '0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else if (ev.start) begin
            phase  <= ST_ADDR;
            bitcnt <= '0;
            in_ack <= 1'b0;
            ack    <= 1'b0;
            idx    <= '0;
        end else if (ev.stop) begin
            phase  <= ST_IDLE;
            bitcnt <= '0;
            in_ack <= 1'b0;
            ack    <= 1'b0;
        end else if (phase != ST_IDLE) begin
            if (ev.rise && !in_ack && bitcnt != 4'd8) begin
                shreg  <= {shreg[6:0], ev.bit_val};
                bitcnt <= bitcnt + 4'd1;
            end
            if (ev.fall) begin
                if (!in_ack && bitcnt == 4'd8) begin
                    in_ack <= 1'b1;
                    ack    <= accept;
                    if (phase == ST_DATA && accept) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= shreg;
                    end
                end else if (in_ack) begin
                    in_ack <= 1'b0;
                    ack    <= 1'b0;
                    bitcnt <= '0;
                    phase  <= next_phase(phase, ack);
                    if (phase == ST_DATA && ack) begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    assign sda_pull = ack;
endmodule

// File: rtl/scs_reg_bank.sv
module scs_reg_bank
    import scs_pkg::*;
#(
    parameter int  NREG   = 10,
    parameter int  EN_REG = 2,
    localparam int IDXW   = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_flat[g*8 +: 8] <= reg_default(g, EN_REG);
            end else if (wr_en && wr_idx == IDXW'(g)) begin
                regs_flat[g*8 +: 8] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/scs_clk_gate.sv
module scs_clk_gate (
    input  logic ref_clk,
    input  logic rst,
    input  logic en_req,
    output logic gclk
);
    logic en_q;

    always_ff @(negedge ref_clk) begin
        if (rst) begin
            en_q <= 1'b1;
        end else begin
            en_q <= en_req;
        end
    end

    assign gclk = ref_clk & en_q;
endmodule

// File: rtl/scs_slave.sv
module scs_slave
    import scs_pkg::*;
#(
    parameter int         NREG      = 10,
    parameter int         NCLK      = 8,
    parameter int         EN_REG    = 2,
    parameter logic [7:0] ADDR_BYTE = 8'hD2,
    localparam int        IDXW      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              por,
    input  logic              pwr_dn,
    input  logic              scl,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [NCLK-1:0]   ref_clk,
    output logic [NREG*8-1:0] cfg_regs,
    output logic [NCLK-1:0]   clk_out
);
    line_ev_t        ev;
    phase_t          phase;
    logic [IDXW-1:0] idx;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;
    logic [7:0]      en_byte;

    scs_line_sampler u_line (
        .clk (clk),
        .rst (por),
        .scl (scl),
        .sda (sda_in),
        .ev  (ev)
    );

    scs_byte_engine #(
        .NREG      (NREG),
        .ADDR_BYTE (ADDR_BYTE)
    ) u_engine (
        .clk      (clk),
        .rst      (por),
        .ev       (ev),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .phase    (phase),
        .idx      (idx)
    );

    scs_reg_bank #(
        .NREG   (NREG),
        .EN_REG (EN_REG)
    ) u_bank (
        .clk       (clk),
        .rst       (por),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );

    assign en_byte = cfg_regs[EN_REG*8 +: 8];

    for (genvar i = 0; i < NCLK; i++) begin : g_gate
        scs_clk_gate u_gate (
            .ref_clk (ref_clk[i]),
            .rst     (por),
            .en_req  (en_byte[i] & ~pwr_dn),
            .gclk    (clk_out[i])
        );
    end
endmodule

// File: rtl/scs_slave_chk.sv
module scs_slave_chk
    import scs_pkg::*;
#(
    parameter int  NREG = 10,
    localparam int IDXW = $clog2(NREG + 1)
) (
    input logic              clk,
    input logic              por,
    input line_ev_t          ev,
    input phase_t            phase,
    input logic [IDXW-1:0]   idx,
    input logic              sda_pull,
    input logic              wr_en,
    input logic [NREG*8-1:0] cfg_regs
);
    // R1: a stop condition always leaves the engine idle
    a_r1_idle_after_stop: assert property (@(posedge clk) disable iff (por)
        $past(ev.stop) |-> phase == ST_IDLE);

    // R2: acknowledge drive moves only while the sampled serial clock is low
    a_r2_ack_moves_scl_low: assert property (@(posedge clk) disable iff (por)
        ($changed(sda_pull) && !$past(ev.start) && !$past(ev.stop)) |-> !$past(ev.scl_hi));

    // R4: a rejected transfer never drives an acknowledge
    a_r4_skip_silent: assert property (@(posedge clk) disable iff (por)
        phase == ST_SKIP |-> !sda_pull);

    // R6: register writes happen only in the data phase
    a_r6_write_in_data: assert property (@(posedge clk) disable iff (por)
        wr_en |-> phase == ST_DATA);

    // R7: register index never passes the bank size
    a_r7_index_bound: assert property (@(posedge clk) disable iff (por)
        idx <= IDXW'(NREG));

    // R9: register contents change only through a write strobe
    a_r9_regs_hold: assert property (@(posedge clk) disable iff (por)
        $changed(cfg_regs) |-> $past(wr_en));
endmodule

bind scs_slave scs_slave_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .por      (por),
    .ev       (ev),
    .phase    (phase),
    .idx      (idx),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .cfg_regs (cfg_regs)
);

// File: tb/scs_slave_test.sv
`timescale 1ns/1ps
module scs_slave_test;
    localparam int NREG = 10;
    localparam int NCLK = 8;

    logic              clk = 1'b0;
    logic              por;
    logic              pwr_dn;
    logic              scl;
    logic              m_sda;
    logic              sda_in;
    logic              sda_pull;
    logic [NCLK-1:0]   ref_clk;
    logic [NREG*8-1:0] cfg_regs;
    logic [NCLK-1:0]   clk_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] exp_reg [NREG];
    int         edge_cnt [NCLK];
    int         short_cnt = 0;

    typedef struct {
        logic  ack;
        string req;
    } exp_item_t;
    exp_item_t exp_q[$];
    event      ack_slot;

    always #5 clk = ~clk;

    assign sda_in = m_sda & ~sda_pull;

    scs_slave uut (
        .clk      (clk),
        .por      (por),
        .pwr_dn   (pwr_dn),
        .scl      (scl),
        .sda_in   (sda_in),
        .sda_pull (sda_pull),
        .ref_clk  (ref_clk),
        .cfg_regs (cfg_regs),
        .clk_out  (clk_out)
    );

    for (genvar i = 0; i < NCLK; i++) begin : g_ref
        localparam realtime HALF = 20.0 + 2.0 * i;
        realtime t_rise = 0.0;
        initial begin
            ref_clk[i] = 1'b0;
            forever #(HALF) ref_clk[i] = ~ref_clk[i];
        end
        initial edge_cnt[i] = 0;
        always @(posedge clk_out[i]) begin
            edge_cnt[i] = edge_cnt[i] + 1;
            t_rise = $realtime;
        end
        // R12: every high pulse spans a full reference high phase
        always @(negedge clk_out[i]) begin
            if ($realtime - t_rise < HALF - 0.01) short_cnt = short_cnt + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expectation per acknowledge slot
    initial begin
        forever begin
            @(ack_slot);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.req, {31'd0, ~sda_in}, {31'd0, it.ack});
            end
        end
    end

    task automatic put_bit(logic b);
        m_sda = b;
        tick(3);
        scl = 1'b1;
        tick(5);
        scl = 1'b0;
        tick(3);
    endtask

    task automatic send_byte(logic [7:0] b, logic exp_ack, string req);
        exp_item_t it;
        for (int k = 7; k >= 0; k--) put_bit(b[k]);
        m_sda = 1'b1;
        tick(3);
        scl = 1'b1;
        tick(2);
        it.ack = exp_ack;
        it.req = req;
        exp_q.push_back(it);
        ->ack_slot;
        tick(3);
        scl = 1'b0;
        tick(3);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(2);
        scl = 1'b1;
        tick(3);
        m_sda = 1'b0;
        tick(3);
        scl = 1'b0;
        tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(2);
        scl = 1'b1;
        tick(3);
        m_sda = 1'b1;
        tick(4);
    endtask

    task automatic open_write(string req);
        bus_start();
        send_byte(8'hD2, 1'b1, req);
        send_byte(8'h5A, 1'b1, "R5 command byte");
        send_byte(8'h07, 1'b1, "R5 count byte");
    endtask

    task automatic check_regs(string req);
        for (int k = 0; k < NREG; k++) check(req, {24'd0, cfg_regs[k*8 +: 8]}, {24'd0, exp_reg[k]});
    endtask

    task automatic check_clocks(logic [7:0] en, string req);
        int   snap [NCLK];
        logic [7:0] act;
        tick(20);
        for (int i = 0; i < NCLK; i++) snap[i] = edge_cnt[i];
        tick(200);
        for (int i = 0; i < NCLK; i++) act[i] = (edge_cnt[i] != snap[i]);
        check(req, {24'd0, act}, {24'd0, en});
    endtask

    task automatic set_defaults();
        for (int k = 0; k < NREG; k++) exp_reg[k] = (k == 2) ? 8'hFF : 8'h00;
    endtask

    initial begin
        #1_500_000;
        fails++;
        tests++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        por    = 1'b1;
        pwr_dn = 1'b0;
        scl    = 1'b1;
        m_sda  = 1'b1;
        tick(6);
        por = 1'b0;
        tick(4);

        // R9 reset state
        set_defaults();
        check_regs("R9 power-on defaults");
        check("R2 no pull after reset", {31'd0, sda_pull}, 0);
        check_clocks(8'hFF, "R11 all clocks enabled by default");

        // R6 sequential load, R5 header ignored
        open_write("R3 address 0xD2 acked");
        send_byte(8'h11, 1'b1, "R6 data 0");
        send_byte(8'h22, 1'b1, "R6 data 1");
        send_byte(8'h5C, 1'b1, "R6 data 2");
        bus_stop();
        exp_reg[0] = 8'h11; exp_reg[1] = 8'h22; exp_reg[2] = 8'h5C;
        check_regs("R6 R5 registers after first write");
        check_clocks(8'h5C, "R11 enable pattern 0x5C");

        // R1 bytes after stop without start are ignored
        send_byte(8'hD2, 1'b0, "R1 no ack after stop");
        send_byte(8'h99, 1'b0, "R1 no ack after stop");
        check_regs("R1 R9 registers kept after stop");

        // R3 R4 wrong address
        bus_start();
        send_byte(8'hD4, 1'b0, "R3 address 0xD4 not acked");
        send_byte(8'h00, 1'b0, "R4 later byte ignored");
        send_byte(8'h00, 1'b0, "R4 later byte ignored");
        send_byte(8'hFF, 1'b0, "R4 later byte ignored");
        bus_stop();
        check_regs("R4 registers unchanged after wrong address");

        // R4 read form
        bus_start();
        send_byte(8'hD3, 1'b0, "R4 read address 0xD3 not acked");
        send_byte(8'h77, 1'b0, "R4 byte after read address ignored");
        bus_stop();
        check_regs("R4 registers unchanged after read address");

        // R7 overflow
        open_write("R3 address acked for full write");
        for (int k = 0; k < NREG; k++) begin
            send_byte(8'h30 + 8'(k), 1'b1, "R7 data within limit");
            exp_reg[k] = 8'h30 + 8'(k);
        end
        send_byte(8'hEE, 1'b0, "R7 eleventh byte not acked");
        send_byte(8'hEF, 1'b0, "R7 twelfth byte not acked");
        bus_stop();
        check_regs("R7 ten registers loaded, overflow dropped");
        check_clocks(8'h32, "R11 enable pattern 0x32");

        // R8 repeated start resets index
        open_write("R8 first transfer");
        send_byte(8'hA1, 1'b1, "R8 data 0");
        send_byte(8'hA2, 1'b1, "R8 data 1");
        open_write("R8 repeated start address");
        send_byte(8'hB1, 1'b1, "R8 data 0 after repeated start");
        bus_stop();
        exp_reg[0] = 8'hB1; exp_reg[1] = 8'hA2;
        check_regs("R8 index restarted at 0");

        // R10 power-down
        pwr_dn = 1'b1;
        tick(20);
        check("R10 outputs low in power-down", {24'd0, clk_out}, 0);
        check_clocks(8'h00, "R10 no edges in power-down");
        check_regs("R10 registers kept in power-down");
        pwr_dn = 1'b0;
        check_clocks(8'h32, "R10 outputs resume after power-down");

        // R12 repeated enable toggling at varied phases
        for (int n = 0; n < 8; n++) begin
            open_write("R12 toggle address");
            send_byte(8'h01, 1'b1, "R12 toggle data 0");
            send_byte(8'h02, 1'b1, "R12 toggle data 1");
            send_byte((n % 2 == 0) ? 8'h00 : 8'hFF, 1'b1, "R12 toggle enable");
            tick(n + 1);
            bus_stop();
        end
        exp_reg[0] = 8'h01; exp_reg[1] = 8'h02; exp_reg[2] = 8'hFF;
        check_regs("R12 registers after toggling");
        check_clocks(8'hFF, "R11 all enabled after toggling");
        check("R12 no shortened pulses", short_cnt, 0);

        // R9 power-on reset restores defaults
        por = 1'b1;
        tick(10);
        por = 1'b0;
        tick(4);
        set_defaults();
        check_regs("R9 defaults after second reset");

        tick(20);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule